// File: doc/BRIEF.md
# LCD Segment Line Latch and Level Selector

This block sits at the output end of a dot-matrix segment driver. A capture stage upstream assembles one complete line of pixel bits. The block copies that line into an output latch when it sees a falling edge on the line clock. It then turns every latched pixel into a two-bit drive-level code for the analog stage that follows. The analog level shifting and the output switches are outside this block; it only produces the per-channel codes.

The drive level for a channel comes from the latched pixel and the frame-alternation input. The two are combined with an exclusive-OR, so each channel reverses polarity on every frame. An active-low blanking input acts combinationally. It sends every channel to the middle level and leaves the latch contents untouched. A reduced-width mode keeps only a central window of channels active. The channels outside that window always show the not-selected level for the current frame phase.

The line clock is sampled by the system clock. A falling edge is detected when the sampled value was high and the live input is low. The latch loads on that same system clock edge.

Top module: `lcdseg_top`

## Requirements
- R1: When `line_clk` is high at one rising edge of `clk` and low at the next, `line_data` is latched at that second edge, and `level_o` shows the new line from then on.
- R2: Without such a falling edge, the latch is not affected by changes on `line_data` or by rising edges of `line_clk`, so `level_o` keeps its value.
- R3: Channel c drives bits [2c+1:2c] of `level_o`. The codes are 2'b00 for V0, 2'b01 for VM and 2'b10 for V1. With `blank_n` high, a channel shows V1 when its latched pixel XOR `frame_m` is 1 and V0 when it is 0. A pixel value of 1 means selected (ON).
- R4: While `blank_n` is low, every channel shows 2'b01 (VM), combinationally and without waiting for a clock. When `blank_n` returns high, the previously latched line appears again.
- R5: With `full_mode` low, the channels with index below 40 and above 279 (outputs 1..40 and 281..320) show V0 when `frame_m` is 0 and V1 when `frame_m` is 1, whatever their latched pixel. Channels 40..279 follow R3.
- R6: With `full_mode` high, every channel follows R3.
- R7: A change on `frame_m` updates `level_o` at once, without any line clock edge.
- R8: After reset the latch holds all zeros. With `frame_m` low and `blank_n` high, every channel therefore shows V0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_clk | input | 1 | Line clock; its falling edge latches the line |
| line_data | input | NUM_CH | Completed line from the capture stage, bit c for channel c |
| frame_m | input | 1 | Frame-alternation phase |
| blank_n | input | 1 | Active-low display blank; forces VM on every channel |
| full_mode | input | 1 | 1: all channels active; 0: only channels 40..279 active |
| level_o | output | 2*NUM_CH | Per-channel drive-level code, two bits per channel |

## Verification
Each test line is loaded with both frame phases, so a channel that ignores `frame_m` or inverts the XOR shows up as a miscompare. The lines used are all ones, alternating bits, every third bit and a bit pattern scrambled by the index. Between them they separate per-channel mapping errors from errors that affect a whole vector or that come from swapped bit positions. In reduced mode an all-ones line marks the edges of the window at channels 39/40 and 279/280, because those channels must show opposite levels. The hold and blanking tests change the inputs without a falling edge, then restore `blank_n`, to confirm that the latch itself was not disturbed.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;
    typedef enum logic [1:0] {
        LVL_V0 = 2'b00,
        LVL_VM = 2'b01,
        LVL_V1 = 2'b10
    } lvl_e;
endpackage

// File: rtl/lcdseg_edge.sv
module lcdseg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk,
    output logic fall_o
);
    typedef struct packed {
        logic lc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.lc = line_clk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall_o = st_q.lc & ~line_clk;
endmodule

// File: rtl/lcdseg_latch.sv
module lcdseg_latch #(
    parameter int NUM_CH = 320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [NUM_CH-1:0] line_i,
    output logic [NUM_CH-1:0] pix_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] pix;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) st_d.pix = line_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_o = st_q.pix;

    AST_LOAD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (pix_o == $past(line_i))); // R1
    AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(pix_o)); // R2
endmodule

// File: rtl/lcdseg_map.sv
module lcdseg_map
    import lcdseg_pkg::*;
#(
    parameter int NUM_CH = 320,
    parameter int WIN_LO = 40,
    parameter int WIN_HI = 279
) (
    input  logic [NUM_CH-1:0]   pix_i,
    input  logic                frame_m,
    input  logic                blank_n,
    input  logic                full_mode,
    output logic [2*NUM_CH-1:0] level_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam bit IN_WIN = (c >= WIN_LO) && (c <= WIN_HI);
        lvl_e lvl;
        always_comb begin
            if (!blank_n)
                lvl = LVL_VM;
            else if (!full_mode && !IN_WIN)
                lvl = frame_m ? LVL_V1 : LVL_V0;
            else
                lvl = (pix_i[c] ^ frame_m) ? LVL_V1 : LVL_V0;
        end
        assign level_o[2*c +: 2] = lvl;
    end
endmodule

// File: rtl/lcdseg_top.sv
module lcdseg_top #(
    parameter int NUM_CH     = 320,
    parameter int REDUCED_LO = 40,
    parameter int REDUCED_HI = 279
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_clk,
    input  logic [NUM_CH-1:0]   line_data,
    input  logic                frame_m,
    input  logic                blank_n,
    input  logic                full_mode,
    output logic [2*NUM_CH-1:0] level_o
);
    logic              fall_w;
    logic [NUM_CH-1:0] pix_w;

    lcdseg_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_clk (line_clk),
        .fall_o   (fall_w)
    );

    lcdseg_latch #(.NUM_CH(NUM_CH)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (fall_w),
        .line_i (line_data),
        .pix_o  (pix_w)
    );

    lcdseg_map #(.NUM_CH(NUM_CH), .WIN_LO(REDUCED_LO), .WIN_HI(REDUCED_HI)) u_map (
        .pix_i     (pix_w),
        .frame_m   (frame_m),
        .blank_n   (blank_n),
        .full_mode (full_mode),
        .level_o   (level_o)
    );

    AST_BLANK_MID: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> (level_o == {NUM_CH{2'b01}})); // R4
    AST_XOR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && full_mode) |-> (level_o[1:0] == ((pix_w[0] ^ frame_m) ? 2'b10 : 2'b00))); // R3

    if (REDUCED_LO > 0) begin : g_unused_chk
        AST_UNUSED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (blank_n && !full_mode) |-> (level_o[1:0] == (frame_m ? 2'b10 : 2'b00))); // R5
    end
endmodule

// File: tb/lcdseg_top_bench.sv
`timescale 1ns/1ps
module lcdseg_top_bench;
    localparam int N  = 320;
    localparam int LO = 40;
    localparam int HI = 279;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           line_clk = 1'b0;
    logic [N-1:0]   line_data = '0;
    logic           frame_m = 1'b0;
    logic           blank_n = 1'b1;
    logic           full_mode = 1'b1;
    logic [2*N-1:0] level_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [N-1:0] model_line = '0;

    always #2.5 clk = ~clk;

    lcdseg_top #(.NUM_CH(N), .REDUCED_LO(LO), .REDUCED_HI(HI)) u_lcdseg_top (
        .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .line_data(line_data),
        .frame_m(frame_m), .blank_n(blank_n), .full_mode(full_mode), .level_o(level_o)
    );

    function automatic logic [2*N-1:0] expect_vec(input logic [N-1:0] pix, input logic m,
                                                   input logic bl_n, input logic full);
        logic [2*N-1:0] v;
        for (int c = 0; c < N; c++) begin
            if (!bl_n)                          v[2*c +: 2] = 2'b01;
            else if (!full && (c < LO || c > HI)) v[2*c +: 2] = m ? 2'b10 : 2'b00;
            else                                v[2*c +: 2] = (pix[c] ^ m) ? 2'b10 : 2'b00;
        end
        return v;
    endfunction

    function automatic logic [N-1:0] make_pat(input int kind);
        logic [N-1:0] p;
        for (int c = 0; c < N; c++) begin
            case (kind)
                0:       p[c] = 1'b1;
                1:       p[c] = c[0];
                2:       p[c] = (c % 3) == 0;
                default: p[c] = ((c * 7 + 3) % 5) < 2;
            endcase
        end
        return p;
    endfunction

    task automatic check(input string req, input logic [2*N-1:0] exp);
        n_chk++;
        if (level_o !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, level_o, exp);
        end
    endtask

    // Drive a full line-clock pulse; falling edge registered, sample after load.
    task automatic load_line(input logic [N-1:0] d);
        @(negedge clk);
        line_data = d;
        line_clk  = 1'b1;
        @(negedge clk);
        line_clk  = 1'b0;
        @(negedge clk);
        model_line = d;
    endtask

    task automatic t_reset;
        check("R8 reset state", expect_vec('0, 1'b0, 1'b1, 1'b1));
    endtask

    task automatic t_full_patterns;
        full_mode = 1'b1;
        for (int k = 0; k < 4; k++) begin
            load_line(make_pat(k));
            frame_m = 1'b0;
            #1;
            check("R1 R3 R6 load m=0", expect_vec(model_line, 1'b0, 1'b1, 1'b1));
            frame_m = 1'b1;
            #1;
            check("R7 R3 m flip without edge", expect_vec(model_line, 1'b1, 1'b1, 1'b1));
            frame_m = 1'b0;
        end
    endtask

    task automatic t_hold;
        load_line(make_pat(1));
        @(negedge clk);
        line_data = ~make_pat(1);
        line_clk  = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 no fall keeps line", expect_vec(model_line, frame_m, 1'b1, 1'b1));
        line_data = make_pat(0);
        repeat (2) @(negedge clk);
        check("R2 data change ignored", expect_vec(model_line, frame_m, 1'b1, 1'b1));
        line_clk = 1'b0;
        @(negedge clk);
        model_line = make_pat(0);
        check("R1 load after held high", expect_vec(model_line, frame_m, 1'b1, 1'b1));
    endtask

    task automatic t_blank;
        load_line(make_pat(3));
        #1;
        blank_n = 1'b0;
        #0.5;
        check("R4 blank immediate", {N{2'b01}});
        frame_m = 1'b1;
        #0.5;
        check("R4 blank ignores m", {N{2'b01}});
        @(negedge clk);
        blank_n = 1'b1;
        #0.5;
        check("R4 latch kept after blank", expect_vec(model_line, 1'b1, 1'b1, 1'b1));
        frame_m = 1'b0;
    endtask

    task automatic t_reduced;
        full_mode = 1'b0;
        load_line(make_pat(0));
        check("R5 reduced m=0", expect_vec(model_line, 1'b0, 1'b1, 1'b0));
        frame_m = 1'b1;
        #1;
        check("R5 reduced m=1", expect_vec(model_line, 1'b1, 1'b1, 1'b0));
        load_line(make_pat(2));
        check("R5 reduced pattern", expect_vec(model_line, 1'b1, 1'b1, 1'b0));
        blank_n = 1'b0;
        #1;
        check("R4 blank in reduced", {N{2'b01}});
        blank_n = 1'b1;
        full_mode = 1'b1;
        #1;
        check("R6 back to full", expect_vec(model_line, 1'b1, 1'b1, 1'b1));
        frame_m = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_patterns();
        t_hold();
        t_blank();
        t_reduced();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule